// File: doc/BRIEF.md
# Four-Channel PWM Timer with Dead-Time and Break

The block is a pulse-width modulation timer with four outputs. A 12-bit up-counter advances on each clock cycle in which the counter enable is high. When it passes its top value (4095) it restarts from a programmable reload value. Every output goes high at that restart and goes low once the counter has met that channel's duty value. So the reload value sets the period and each duty value sets where its pulse ends.

Software reaches the block through a byte-wide register bus. A 12-bit value is written as a high byte and then a low byte, and only the low-byte write commits it as a pending value. Pending reload and duty values sit in shadow registers. They move into the active registers at the first counter wrap after software raises a transfer request, and hardware clears the request when it has done so. Outputs 0 and 1 can be turned into a complementary pair with a guard gap at each switch. Each channel has a polarity and an enable bit. A break input, active at a chosen level, overrides the enabled pins at once with a fixed 4-bit pattern and keeps it there until software releases it.

Top module: `qpt_timer`

## Requirements
- R1: After a synchronous reset all PWM outputs are 0. The overflow flag, the transfer request, the break latch, the polarity, enable, interrupt-enable, dead-time and break settings, and all pending and active reload and duty values are 0. The counter is 0.
- R2: With the counter enable high the counter rises by one per clock. On a clock where it holds 4095 it loads the reload value instead. With the enable low it holds. Register map: 0x00 transfer (bit0), 0x01 status (bit0 overflow, bits 7:4 compare flags), 0x02 config (bits 3:0 polarity, bits 7:4 output enable), 0x03 compare interrupt enables (bits 3:0), 0x04 dead-time (bit7 enable, bits 6:0 length), 0x05 break (bit0 enable, bit1 active level, bit2 latched, bits 7:4 pattern), 0x06/0x07 reload high/low, 0x08+2i/0x09+2i channel i duty high/low.
- R3: A channel's raw output goes high on the clock after a wrap. It goes low on the clock after a counted cycle in which the counter equals that channel's active duty value. A wrap wins over a coincident match, so a duty of 4095 with a reload of 4094 or less keeps the channel high.
- R4: A high-byte write (its low 4 bits) is staged. Only the following low-byte write commits {staged, low byte} as the pending value. Reading a high or low address returns the pending value, so a high-byte write alone changes no readback.
- R5: Writing 1 to bit0 of 0x00 raises a transfer request. At the next wrap the reload used for that wrap, the active reload and all active duty values take their pending values, and bit0 reads 0 again.
- R6: A channel's compare flag is set on any counted cycle in which the counter equals its active duty value. The compare interrupt output is the OR of flags whose enable bit is set. Writing 1 to a status bit 7:4 clears that flag, and a set in the same clock wins.
- R7: The overflow flag is set by each wrap and cleared by writing 1 to status bit0. A set in the same clock wins.
- R8: A polarity bit inverts its channel's output.
- R9: A channel whose output-enable bit is 0 drives 0, and this includes during break.
- R10: With dead-time enabled, output 0 follows raw channel 0 and output 1 follows its complement, and channel 1's own duty is ignored. Both are held low for the programmed number of clock cycles starting with the cycle in which raw channel 0 changes. The two never overlap high.
- R11: While break is enabled and the break input is at the selected level, the enabled outputs show the pattern in the same cycle, after polarity inversion. The condition sets the break latch, which holds the pattern until a write to 0x05 with bit2 = 0 is made while the condition is absent. With break disabled the input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Register address, used for both read and write |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one write per high clock |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cnt_en | input | 1 | Counter clock enable |
| brk_in | input | 1 | Break input, not synchronised |
| pwm_out | output | 4 | PWM outputs, bit i is channel i |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
The assertions assume the break input and bus signals change away from the clock edge, and that the dead-time length stays steady across the cycle in which output 0 rises. The stimulus changes every input 1 ns after a rising edge. It rewrites the dead-time register only while the guard comparison is not about to fire. The assertions also assume that at most one bus write arrives per clock. Writes are issued one at a time, with a high byte always followed by its low byte.

// File: rtl/qpt_pkg.sv
`timescale 1ns/1ps
// qpt_pkg: widths and register addresses shared by the PWM timer.
// Assumes a 12-bit counter accessed as high nibble plus low byte.
package qpt_pkg;
    localparam int CW   = 12;
    localparam int DW   = 8;
    localparam int AW   = 5;
    localparam int NCH  = 4;
    localparam int DTW  = 7;
    localparam int HW   = CW - DW;

    localparam logic [AW-1:0] A_XFER  = 5'h00;
    localparam logic [AW-1:0] A_STAT  = 5'h01;
    localparam logic [AW-1:0] A_CFG   = 5'h02;
    localparam logic [AW-1:0] A_IEN   = 5'h03;
    localparam logic [AW-1:0] A_DEAD  = 5'h04;
    localparam logic [AW-1:0] A_BRK   = 5'h05;
    localparam logic [AW-1:0] A_RLD_H = 5'h06;
    localparam logic [AW-1:0] A_RLD_L = 5'h07;
    localparam int            A_DUTY0 = 8;

    function automatic logic [AW-1:0] duty_hi_addr(input int ch);
        return AW'(A_DUTY0 + 2 * ch);
    endfunction

    function automatic logic [AW-1:0] duty_lo_addr(input int ch);
        return AW'(A_DUTY0 + 2 * ch + 1);
    endfunction
endpackage

// File: rtl/qpt_regs.sv
`timescale 1ns/1ps
// qpt_regs: register file, pending/active double buffering, sticky flags
// and the break latch. Assumes at most one bus write per clock.
module qpt_regs
    import qpt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic                    wr_en,
    input  logic                    ovf_ev,
    input  logic [NCH-1:0]          cmp_ev,
    input  logic                    brk_in,
    output logic [CW-1:0]           rld_load,
    output logic [NCH-1:0][CW-1:0]  dcr_act,
    output logic [NCH-1:0]          pol,
    output logic [NCH-1:0]          oe,
    output logic                    dt_en,
    output logic [DTW-1:0]          dt_val,
    output logic                    brk_force,
    output logic [NCH-1:0]          brk_pat,
    output logic                    ovf_flag,
    output logic                    cmp_irq,
    output logic [DW-1:0]           rdata
);
    logic [HW-1:0]           hi_stage;
    logic [CW-1:0]           rld_pre, rld_act;
    logic [NCH-1:0][CW-1:0]  dcr_pre;
    logic                    xfer;
    logic [NCH-1:0]          cmpie, cmp_flag;
    logic                    brk_en, brk_lvl, brk_lat, brk_cond;
    logic                    xfer_now, hi_wr;

    assign xfer_now  = xfer && ovf_ev;
    assign rld_load  = xfer ? rld_pre : rld_act;
    assign brk_cond  = brk_en && (brk_in == brk_lvl);
    assign brk_force = brk_cond || brk_lat;
    assign cmp_irq   = |(cmp_flag & cmpie);
    assign hi_wr     = wr_en && !addr[0] && (addr >= A_RLD_H)
                       && (addr <= duty_hi_addr(NCH - 1));

    // Staging nibble for the high byte of any 12-bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_stage <= '0;
        else if (hi_wr) hi_stage <= wdata[HW-1:0];
    end

    // Pending values committed by low-byte writes, moved to active on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_pre <= '0;
            rld_act <= '0;
            dcr_pre <= '0;
            dcr_act <= '0;
        end else begin
            if (xfer_now) begin
                rld_act <= rld_pre;
                dcr_act <= dcr_pre;
            end
            if (wr_en && addr == A_RLD_L) rld_pre <= {hi_stage, wdata};
            for (int i = 0; i < NCH; i++) begin
                if (wr_en && addr == duty_lo_addr(i)) dcr_pre[i] <= {hi_stage, wdata};
            end
        end
    end

    // Transfer request: set by software, cleared when a wrap performs it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 xfer <= 1'b0;
        else if (xfer_now)                          xfer <= 1'b0;
        else if (wr_en && addr == A_XFER && wdata[0]) xfer <= 1'b1;
    end

    // Plain configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol <= '0; oe <= '0; cmpie <= '0;
            dt_en <= 1'b0; dt_val <= '0;
            brk_en <= 1'b0; brk_lvl <= 1'b0; brk_pat <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CFG:  begin pol <= wdata[3:0]; oe <= wdata[7:4]; end
                A_IEN:  cmpie <= wdata[3:0];
                A_DEAD: begin dt_en <= wdata[7]; dt_val <= wdata[DTW-1:0]; end
                A_BRK:  begin brk_en <= wdata[0]; brk_lvl <= wdata[1]; brk_pat <= wdata[7:4]; end
                default: ;
            endcase
        end
    end

    // Sticky event flags with write-one-to-clear; a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            cmp_flag <= '0;
        end else begin
            if (ovf_ev)                                   ovf_flag <= 1'b1;
            else if (wr_en && addr == A_STAT && wdata[0]) ovf_flag <= 1'b0;
            for (int i = 0; i < NCH; i++) begin
                if (cmp_ev[i])                                     cmp_flag[i] <= 1'b1;
                else if (wr_en && addr == A_STAT && wdata[4 + i])  cmp_flag[i] <= 1'b0;
            end
        end
    end

    // Break latch: set by the active condition, released by writing bit2 = 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   brk_lat <= 1'b0;
        else if (brk_cond)                            brk_lat <= 1'b1;
        else if (wr_en && addr == A_BRK && !wdata[2]) brk_lat <= 1'b0;
    end

    // Read multiplexer returning pending values for 12-bit registers.
    always_comb begin
        rdata = '0;
        case (addr)
            A_XFER:  rdata = {7'b0, xfer};
            A_STAT:  rdata = {cmp_flag, 3'b0, ovf_flag};
            A_CFG:   rdata = {oe, pol};
            A_IEN:   rdata = {4'b0, cmpie};
            A_DEAD:  rdata = {dt_en, dt_val};
            A_BRK:   rdata = {brk_pat, 1'b0, brk_lat, brk_lvl, brk_en};
            A_RLD_H: rdata = DW'(rld_pre >> DW);
            A_RLD_L: rdata = rld_pre[DW-1:0];
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (addr == duty_hi_addr(i)) rdata = DW'(dcr_pre[i] >> DW);
                    if (addr == duty_lo_addr(i)) rdata = dcr_pre[i][DW-1:0];
                end
            end
        endcase
    end

    a_r5_xfer_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && ovf_ev |=> !xfer);
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !(wr_en && addr == A_STAT && wdata[0]) |=> ovf_flag);
    a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> ovf_flag);
    a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        brk_lat && !(wr_en && addr == A_BRK) |=> brk_lat);
endmodule

// File: rtl/qpt_counter.sv
`timescale 1ns/1ps
// qpt_counter: 12-bit up-counter with reload and per-channel raw PWM state.
// Assumes rld_load already reflects a transfer due at this wrap.
module qpt_counter
    import qpt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cnt_en,
    input  logic [CW-1:0]           rld_load,
    input  logic [NCH-1:0][CW-1:0]  dcr_act,
    output logic                    ovf_ev,
    output logic [NCH-1:0]          cmp_ev,
    output logic [NCH-1:0]          raw
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};
    logic [CW-1:0] cnt;

    assign ovf_ev = cnt_en && (cnt == MAXV);

    // Counter: step on enable, reload on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (ovf_ev) cnt <= rld_load;
        else if (cnt_en) cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic r_q;
        assign cmp_ev[g] = cnt_en && (cnt == dcr_act[g]);
        // Raw output: set on wrap, cleared after a duty match.
        always_ff @(posedge clk) begin
            if (!rst_n)         r_q <= 1'b0;
            else if (ovf_ev)    r_q <= 1'b1;
            else if (cmp_ev[g]) r_q <= 1'b0;
        end
        assign raw[g] = r_q;
    end

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && cnt != MAXV |=> cnt == $past(cnt) + 1'b1);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt));
    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> cnt == $past(rld_load));
    a_r3_set_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> &raw);
endmodule

// File: rtl/qpt_deadtime.sv
`timescale 1ns/1ps
// qpt_deadtime: builds a complementary pair from raw channel A with a guard
// gap, in clock cycles, after each change. Passes A and B through when off.
module qpt_deadtime
    import qpt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dt_en,
    input  logic [DTW-1:0]  dt_val,
    input  logic            raw_a,
    input  logic            raw_b,
    output logic            out_a,
    output logic            out_b
);
    logic           a_prev, chg, block;
    logic [DTW-1:0] gap_cnt;

    assign chg   = raw_a ^ a_prev;
    assign block = dt_en && ((chg && dt_val != '0) || gap_cnt != '0);
    assign out_a = dt_en ? (raw_a && !block)  : raw_a;
    assign out_b = dt_en ? (!raw_a && !block) : raw_b;

    // Edge tracker and gap down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_prev  <= 1'b0;
            gap_cnt <= '0;
        end else begin
            a_prev <= raw_a;
            if (chg)                 gap_cnt <= (dt_val == '0) ? '0 : dt_val - 1'b1;
            else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
        end
    end

    a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
        dt_en && $past(dt_en) && dt_val != '0 && $stable(dt_val) && $rose(out_a)
        |-> !$past(out_b));
endmodule

// File: rtl/qpt_outstage.sv
`timescale 1ns/1ps
// qpt_outstage: polarity, break override and output enable, purely
// combinational so break acts in the cycle the input arrives.
module qpt_outstage
    import qpt_pkg::*;
(
    input  logic [NCH-1:0] pre,
    input  logic [NCH-1:0] pol,
    input  logic [NCH-1:0] oe,
    input  logic           brk_force,
    input  logic [NCH-1:0] brk_pat,
    output logic [NCH-1:0] pins
);
    logic [NCH-1:0] shaped;
    assign shaped = brk_force ? brk_pat : (pre ^ pol);
    assign pins   = shaped & oe;
endmodule

// File: rtl/qpt_timer.sv
`timescale 1ns/1ps
// qpt_timer: top of the four-channel PWM timer. Connects the register file,
// counter, dead-time pair on channels 0/1 and the output stage.
module qpt_timer
    import qpt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [4:0]     bus_addr,
    input  logic [7:0]     bus_wdata,
    input  logic           bus_wr,
    output logic [7:0]     bus_rdata,
    input  logic           cnt_en,
    input  logic           brk_in,
    output logic [3:0]     pwm_out,
    output logic           ovf_flag,
    output logic           cmp_irq
);
    logic [CW-1:0]          rld_load;
    logic [NCH-1:0][CW-1:0] dcr_act;
    logic [NCH-1:0]         pol, oe, brk_pat, cmp_ev, raw, pre;
    logic                   dt_en, brk_force, ovf_ev;
    logic [DTW-1:0]         dt_val;

    qpt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr_en(bus_wr),
        .ovf_ev(ovf_ev), .cmp_ev(cmp_ev), .brk_in(brk_in),
        .rld_load(rld_load), .dcr_act(dcr_act), .pol(pol), .oe(oe),
        .dt_en(dt_en), .dt_val(dt_val), .brk_force(brk_force), .brk_pat(brk_pat),
        .ovf_flag(ovf_flag), .cmp_irq(cmp_irq), .rdata(bus_rdata)
    );

    qpt_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .rld_load(rld_load),
        .dcr_act(dcr_act), .ovf_ev(ovf_ev), .cmp_ev(cmp_ev), .raw(raw)
    );

    qpt_deadtime u_dt (
        .clk(clk), .rst_n(rst_n), .dt_en(dt_en), .dt_val(dt_val),
        .raw_a(raw[0]), .raw_b(raw[1]), .out_a(pre[0]), .out_b(pre[1])
    );

    assign pre[NCH-1:2] = raw[NCH-1:2];

    qpt_outstage u_out (
        .pre(pre), .pol(pol), .oe(oe), .brk_force(brk_force),
        .brk_pat(brk_pat), .pins(pwm_out)
    );
endmodule

// File: tb/qpt_timer_tb.sv
`timescale 1ns/1ps
module qpt_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = 5'h01;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic       cnt_en = 1'b0;
    logic       brk_in = 1'b0;
    logic [3:0] pwm_out;
    logic       ovf_flag, cmp_irq;

    always #2.5 clk = ~clk;

    qpt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .cnt_en(cnt_en), .brk_in(brk_in),
        .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_irq(cmp_irq)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    string tag = "R1";
    bit checking = 0;

    // Behavioural reference state
    int m_cnt, m_rld_act, m_rld_pre, m_hi, m_dtv, m_gap;
    int m_dact [4];
    int m_dpre [4];
    bit m_xfer, m_of, m_dte, m_ben, m_blv, m_blat;
    bit [3:0] m_raw, m_pol, m_oe, m_ie, m_cf, m_bpat;
    bit ov, bc;
    bit [3:0] cm, nraw;

    task automatic chk(input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    function automatic int exp_pwm();
        bit blk, d0, d1;
        bit [3:0] v;
        blk = (m_gap > 0);
        d0 = m_dte ? (m_raw[0] && !blk) : m_raw[0];
        d1 = m_dte ? (!m_raw[0] && !blk) : m_raw[1];
        v = {m_raw[3], m_raw[2], d1, d0} ^ m_pol;
        if (m_blat || (m_ben && (brk_in == m_blv))) v = m_bpat;
        return int'(v & m_oe);
    endfunction

    function automatic int exp_rd(input int a);
        case (a)
            0: return int'(m_xfer);
            1: return (int'(m_cf) << 4) | int'(m_of);
            2: return (int'(m_oe) << 4) | int'(m_pol);
            3: return int'(m_ie);
            4: return (int'(m_dte) << 7) | m_dtv;
            5: return (int'(m_bpat) << 4) | (int'(m_blat) << 2) | (int'(m_blv) << 1) | int'(m_ben);
            6: return m_rld_pre >> 8;
            7: return m_rld_pre & 255;
            default: begin
                if (a >= 8 && a <= 15) begin
                    if (a % 2 == 0) return m_dpre[(a - 8) / 2] >> 8;
                    else            return m_dpre[(a - 8) / 2] & 255;
                end
                return 0;
            end
        endcase
    endfunction

    // Reference model update at each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_rld_act = 0; m_rld_pre = 0; m_hi = 0; m_dtv = 0; m_gap = 0;
            for (int i = 0; i < 4; i++) begin m_dact[i] = 0; m_dpre[i] = 0; end
            m_xfer = 0; m_of = 0; m_dte = 0; m_ben = 0; m_blv = 0; m_blat = 0;
            m_raw = 0; m_pol = 0; m_oe = 0; m_ie = 0; m_cf = 0; m_bpat = 0;
        end else begin
            ov = cnt_en && (m_cnt == 4095);
            for (int i = 0; i < 4; i++) cm[i] = cnt_en && (m_cnt == m_dact[i]);
            bc = m_ben && (brk_in == m_blv);
            for (int i = 0; i < 4; i++) nraw[i] = ov ? 1'b1 : (cm[i] ? 1'b0 : m_raw[i]);
            if (cnt_en) m_cnt = ov ? (m_xfer ? m_rld_pre : m_rld_act) : m_cnt + 1;
            if (ov && m_xfer) begin
                m_rld_act = m_rld_pre;
                for (int i = 0; i < 4; i++) m_dact[i] = m_dpre[i];
                m_xfer = 0;
            end else if (bus_wr && bus_addr == 0 && bus_wdata[0]) m_xfer = 1;
            if (ov) m_of = 1;
            else if (bus_wr && bus_addr == 1 && bus_wdata[0]) m_of = 0;
            for (int i = 0; i < 4; i++) begin
                if (cm[i]) m_cf[i] = 1;
                else if (bus_wr && bus_addr == 1 && bus_wdata[4 + i]) m_cf[i] = 0;
            end
            if (bc) m_blat = 1;
            else if (bus_wr && bus_addr == 5 && !bus_wdata[2]) m_blat = 0;
            if (bus_wr) begin
                case (int'(bus_addr))
                    2: begin m_pol = bus_wdata[3:0]; m_oe = bus_wdata[7:4]; end
                    3: m_ie = bus_wdata[3:0];
                    4: begin m_dte = bus_wdata[7]; m_dtv = int'(bus_wdata[6:0]); end
                    5: begin m_ben = bus_wdata[0]; m_blv = bus_wdata[1]; m_bpat = bus_wdata[7:4]; end
                    7: m_rld_pre = m_hi * 256 + int'(bus_wdata);
                    9, 11, 13, 15: m_dpre[(int'(bus_addr) - 9) / 2] = m_hi * 256 + int'(bus_wdata);
                    6, 8, 10, 12, 14: m_hi = int'(bus_wdata[3:0]);
                    default: ;
                endcase
            end
            if (nraw[0] != m_raw[0]) m_gap = m_dtv;
            else if (m_gap > 0) m_gap--;
            m_raw = nraw;
        end
    end

    // Compare all outputs against the model in mid-cycle
    always @(negedge clk) begin
        if (checking) begin
            chk("pwm_out", int'(pwm_out), exp_pwm());
            chk("ovf_flag", int'(ovf_flag), int'(m_of));
            chk("cmp_irq", int'(cmp_irq), int'(|(m_cf & m_ie)));
            chk($sformatf("rdata@%0h", bus_addr), int'(bus_rdata), exp_rd(int'(bus_addr)));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog expired got=%0d exp=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        bus_addr = 5'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic peek(input int a, input int n);
        @(posedge clk); #1;
        bus_addr = 5'(a);
        idle(n);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        #0 checking = 1;
        // R1: reset state, all readbacks
        for (int a = 0; a < 16; a++) peek(a, 1);
        tag = "R4";
        wr(6, 8'h0F); peek(7, 2); peek(6, 2);
        wr(7, 8'hA0); peek(7, 2);
        wr(8, 8'h0F); wr(9, 8'hC8);
        wr(10, 8'h0F); peek(9, 1); wr(11, 8'hDC);
        wr(12, 8'h0F); wr(13, 8'hFF);
        wr(14, 8'h0F); wr(15, 8'h96);
        for (int a = 6; a < 16; a++) peek(a, 1);
        wr(2, 8'hF0); wr(3, 8'h05);
        tag = "R5";
        wr(0, 1); cnt_en = 1'b1; peek(0, 4300);
        tag = "R3";
        peek(1, 300);
        tag = "R6";
        wr(1, 8'hF0); idle(150);
        wr(3, 8'h0A); idle(150);
        tag = "R7";
        wr(1, 8'h01); idle(40); wr(1, 8'h01); idle(150);
        tag = "R8";
        wr(2, 8'hF5); idle(250);
        tag = "R9";
        wr(2, 8'h90); idle(250);
        tag = "R10";
        wr(2, 8'hF0); wr(4, 8'h85); peek(4, 300);
        wr(4, 8'h80); idle(200);
        wr(4, 8'h00); idle(20);
        tag = "R11";
        wr(5, 8'hA2); peek(5, 2);
        brk_in = 1'b1; idle(5); brk_in = 1'b0; idle(5);
        wr(5, 8'hA3); idle(3);
        brk_in = 1'b1; idle(3); brk_in = 1'b0; idle(20);
        brk_in = 1'b1; wr(5, 8'hA3); idle(5); brk_in = 1'b0; idle(5);
        wr(5, 8'hA3); idle(20);
        wr(2, 8'hF5); brk_in = 1'b1; idle(4); brk_in = 1'b0; idle(4);
        wr(5, 8'hA1); idle(10);
        wr(5, 8'h00); wr(2, 8'hF0); idle(10);
        tag = "R2";
        cnt_en = 1'b0; peek(1, 60);
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #1; cnt_en = (i % 3 != 0);
        end
        cnt_en = 1'b1;
        tag = "R5";
        wr(8, 8'h0F); wr(9, 8'hA8); wr(6, 8'h0F); wr(7, 8'hB0);
        wr(0, 1); peek(0, 400);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule